// File: doc/BRIEF.md
# Self-Correcting Johnson Decade Counter

This block counts through ten states in a five-bit twisted ring. It shows the current state on ten registered, active-high decoded lines, exactly one high at a time, and on an active-low carry line that is low for the upper half of the decade. Two count inputs step the ring. One steps on its rising edge while the other is low. The other steps on its falling edge while the first is high. Both inputs are brought onto the system clock through a two-flop synchronizer, and their edges are found there.

A master clear forces state 0 at once and is released in step with the clock. A ring code outside the ten legal patterns is repaired on the next qualifying step, which always lands on state 0. To build longer counters, the carry of one block is wired to the rising-edge input of the next. The next block then advances once per full decade of the first.

Top module: `jdecade_ctr`

## Requirements
- R1: While `clr` is high, `dec` is 10'b0000000001 and `carry_n` is 1, asynchronously, whatever the count inputs do.
- R2: A low-to-high change on `rise_in` while `fall_in` is low advances the counter by exactly one state.
- R3: A high-to-low change on `fall_in` while `rise_in` is high advances the counter by exactly one state.
- R4: Nothing else changes the state: a `rise_in` edge while `fall_in` is high, a `fall_in` edge while `rise_in` is low, a rising `fall_in`, a falling `rise_in`, and steady levels are all ignored.
- R5: In state k (0..9) only bit k of `dec` is high. Advancing moves the high bit up by one, and state 9 wraps to state 0.
- R6: `carry_n` is 0 in states 5 to 9 and 1 in states 0 to 4.
- R7: With `carry_n` wired to the `rise_in` of a second block, the second block advances once each time the first wraps from state 9 to state 0, and at no other time.
- R8: From any of the 22 illegal ring codes, the next qualifying step puts the counter in state 0, well inside the 11-step limit. Counting then continues in legal order.
- R9: Releasing `clr` never counts, even with `rise_in` or `fall_in` held high across the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples both count inputs |
| clr | input | 1 | Master clear, active high, asynchronous assert, synchronous release |
| rise_in | input | 1 | Count input stepping on its rising edge while `fall_in` is low |
| fall_in | input | 1 | Count input stepping on its falling edge while `rise_in` is high |
| dec | output | 10 | Registered one-hot decode of the state, bit k in state k |
| carry_n | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
The bench goes after the cross-qualification of the two inputs. A design that ignores the level of the other input would take an extra count when one input's edge arrives while the other holds the blocking level. Each of the 22 illegal ring codes is injected. A design without repair would keep cycling a wrong pattern with several or no decode lines high. The bench releases clear with both inputs high, so a synchronizer that resets to the wrong level shows up as a spurious count. A second block is chained on the carry, so a carry that changes at the wrong state would make the second block count early or twice per decade.

// File: rtl/jdecade_ctr.sv
module jdecade_ctr #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       rise_in,
  input  logic       fall_in,
  output logic [9:0] dec,
  output logic       carry_n
);
  localparam int RW = 5;

  logic [1:0]             clr_sync;
  logic                   rst;
  logic [SYNC_STAGES-1:0] rs, fs;
  logic                   r_prev, f_prev;
  logic                   r_s, f_s;
  logic                   adv, legal;
  logic [RW-1:0]          ring, ring_nxt;
  logic [RW-2:0]          diff;

  function automatic logic [9:0] decode(input logic [RW-1:0] q);
    logic [9:0] d;
    d[0] = ~q[4] & ~q[0];
    d[5] =  q[4] &  q[0];
    for (int k = 1; k < 5; k++) begin
      d[k]   =  q[k-1] & ~q[k];
      d[k+5] = ~q[k-1] &  q[k];
    end
    return d;
  endfunction

  always_ff @(posedge clk or posedge clr)
    if (clr) clr_sync <= 2'b11;
    else     clr_sync <= {clr_sync[0], 1'b0};

  assign rst = clr_sync[1];

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      rs     <= '1;
      r_prev <= 1'b1;
      fs     <= '0;
      f_prev <= 1'b0;
    end else begin
      rs     <= {rs[SYNC_STAGES-2:0], rise_in};
      fs     <= {fs[SYNC_STAGES-2:0], fall_in};
      r_prev <= r_s;
      f_prev <= f_s;
    end

  assign r_s = rs[SYNC_STAGES-1];
  assign f_s = fs[SYNC_STAGES-1];

  assign adv   = (r_s & ~r_prev & ~f_s) | (f_prev & ~f_s & r_s);
  assign diff  = ring[RW-1:1] ^ ring[RW-2:0];
  assign legal = (diff & (diff - 1'b1)) == '0;

  assign ring_nxt = !adv  ? ring :
                    legal ? {ring[RW-2:0], ~ring[RW-1]} : '0;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      ring    <= '0;
      dec     <= 10'd1;
      carry_n <= 1'b1;
    end else begin
      ring    <= ring_nxt;
      dec     <= decode(ring_nxt);
      carry_n <= ~ring_nxt[RW-1];
    end
endmodule

module jdecade_ctr_chk (
  input logic       clk,
  input logic       clr,
  input logic [9:0] dec,
  input logic       carry_n,
  input logic [4:0] ring,
  input logic       adv
);
  function automatic logic lg(input logic [4:0] q);
    int n;
    n = 0;
    for (int i = 0; i < 4; i++) if (q[i] != q[i+1]) n++;
    return n <= 1;
  endfunction

  always @(negedge clk)
    if (clr) p_reset_value_r1: assert (dec == 10'd1 && carry_n);

  p_step_r2: assert property (@(posedge clk) disable iff (clr)
    adv && lg(ring) |=> dec == {$past(dec[8:0]), $past(dec[9])});

  p_hold_r4: assert property (@(posedge clk) disable iff (clr)
    !adv && $stable(ring) |=> $stable(dec) && $stable(carry_n));

  p_onehot_r5: assert property (@(posedge clk) disable iff (clr)
    lg(ring) |-> $onehot(dec));

  p_carry_r6: assert property (@(posedge clk) disable iff (clr)
    lg(ring) |-> carry_n == ~|dec[9:5]);

  p_repair_r8: assert property (@(posedge clk) disable iff (clr)
    adv && !lg(ring) |=> lg(ring) && dec == 10'd1);
endmodule

bind jdecade_ctr jdecade_ctr_chk u_chk (
  .clk(clk), .clr(clr), .dec(dec), .carry_n(carry_n), .ring(ring), .adv(adv)
);

// File: tb/jdecade_ctr_bench.sv
module jdecade_ctr_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       clr = 1'b1, rin = 1'b0, fin = 1'b0;
  logic [9:0] dec, dec2;
  logic       cn, cn2;

  jdecade_ctr u_jdecade_ctr (.clk(clk), .clr(clr), .rise_in(rin), .fall_in(fin),
                             .dec(dec), .carry_n(cn));
  jdecade_ctr u_jdecade_ctr_next (.clk(clk), .clr(clr), .rise_in(cn), .fall_in(1'b0),
                                  .dec(dec2), .carry_n(cn2));

  typedef struct { int unit; int st; string req; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, st = 0, st2 = 0;
  bit done = 0;

  task automatic wait_n(int n); repeat (n) @(negedge clk); endtask

  task automatic push_exp(int unit, int s, string req);
    exp_t e; e.unit = unit; e.st = s; e.req = req; q.push_back(e);
  endtask

  task automatic compare(string req, int unit, int s);
    logic [9:0] d, ed; logic c, ec;
    d  = unit ? dec2 : dec;  c = unit ? cn2 : cn;
    ed = 10'd1 << s;         ec = (s < 5);
    checks++;
    if (d !== ed || c !== ec) begin
      errors++;
      $display("FAIL %s unit%0d: dec=%b carry_n=%b expected dec=%b carry_n=%b",
               req, unit, d, c, ed, ec);
    end
  endtask

  initial forever begin
    @(negedge clk); #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e.req, e.unit, e.st);
    end
  end

  function automatic bit is_legal(int c);
    int n = 0;
    for (int i = 0; i < 4; i++) if (c[i] != c[i+1]) n++;
    return n <= 1;
  endfunction

  task automatic note_wrap(int old);
    if (old == 9) st2 = (st2 + 1) % 10;
  endtask

  task automatic step_rise(string req);
    int old = st;
    fin = 1'b0; rin = 1'b0; wait_n(4);
    rin = 1'b1; wait_n(4);
    rin = 1'b0; wait_n(4);
    st = (st + 1) % 10; note_wrap(old);
    push_exp(0, st, req); push_exp(1, st2, "R7");
  endtask

  task automatic step_fall(string req);
    int old = st;
    rin = 1'b1; fin = 1'b1; wait_n(4);
    fin = 1'b0; wait_n(4);
    rin = 1'b0; wait_n(4);
    st = (st + 1) % 10; note_wrap(old);
    push_exp(0, st, req); push_exp(1, st2, "R7");
  endtask

  initial begin
    wait_n(3);
    push_exp(0, 0, "R1"); wait_n(1);
    clr = 1'b0; wait_n(6);
    push_exp(0, 0, "R9"); push_exp(1, 0, "R9");

    for (int i = 0; i < 10; i++) step_rise("R2_R5_R6");
    for (int i = 0; i < 10; i++) step_fall("R3_R5_R6");

    // R4: rise edge while fall high
    fin = 1'b1; rin = 1'b0; wait_n(4);
    rin = 1'b1; wait_n(4); rin = 1'b0; wait_n(4);
    push_exp(0, st, "R4");
    // R4: fall edge while rise low
    fin = 1'b0; wait_n(4);
    push_exp(0, st, "R4");
    // R4: steady high levels
    rin = 1'b1; fin = 1'b1; wait_n(20);
    push_exp(0, st, "R4");
    rin = 1'b0; fin = 1'b0; wait_n(4);
    push_exp(0, st, "R4");

    for (int i = 0; i < 6; i++) step_rise("R2_R6");

    // R1: asynchronous clear, inputs toggling; R9: release with inputs high
    @(negedge clk); #5 clr = 1'b1; #2 compare("R1", 0, 0);
    st = 0; st2 = 0;
    rin = 1'b1; fin = 1'b1; wait_n(3); rin = 1'b0; wait_n(3); rin = 1'b1; wait_n(3);
    push_exp(0, 0, "R1");
    wait_n(1); clr = 1'b0; wait_n(8);
    push_exp(0, 0, "R9"); push_exp(1, 0, "R9");
    rin = 1'b0; wait_n(4);
    push_exp(0, 0, "R9");
    fin = 1'b0; wait_n(4);
    step_rise("R2");

    // R8: every illegal code recovers on the next step
    for (int c = 0; c < 32; c++) begin
      if (!is_legal(c)) begin
        @(negedge clk);
        force u_jdecade_ctr.ring = 5'(c);
        #1 release u_jdecade_ctr.ring;
        wait_n(2);
        rin = 1'b0; fin = 1'b0; wait_n(4);
        rin = 1'b1; wait_n(4); rin = 1'b0; wait_n(4);
        push_exp(0, 0, "R8");
        rin = 1'b1; wait_n(4); rin = 1'b0; wait_n(4);
        push_exp(0, 1, "R8");
      end
    end

    wait_n(3);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule